// File: doc/BRIEF.md
# Single-Frame Receive Packet Buffer

This block holds one received radio frame between the receive MAC and the host. The MAC side presents bytes one per strobe, marking the first and last byte of each frame. The stored layout is fixed: offset 0 carries the frame length N, offsets 1 to N carry the payload, and offsets N+1 and N+2 carry the link-quality and signal-strength bytes. The host reads any offset at random through a registered read port.

Once a frame has been stored, the buffer is claimed. Later frames are dropped until the host reads offset 0, which re-arms the buffer so that the next frame overwrites it. The host can also block reception with a decode-inhibit bit, abort and re-arm with a one-cycle flush bit, or pulse a soft reset. Completed frames raise a receive flag. Frames whose security-enabled bit is set also raise a security flag. Frames too long for the storage raise an overflow flag instead of the receive flag. Each of the receive and security flags has an enable bit that gates the interrupt output.

Top module: `rx_frame_buf`

## Requirements
- R1: After rst_n is released, irq is 0, stat_data is 0 and cfg_state is 0.
- R2: An accepted frame is stored in arrival order from offset 0 upward. A host read of offset A (host_rd_en high for one cycle) presents the byte stored at A on host_rd_data after the next rising edge.
- R3: A byte that would land at offset DEPTH or beyond is discarded. At the end of such a frame, status bit 2 (overflow) is set, bits 0 and 1 stay clear, and the buffer stays claimed until offset 0 is read.
- R4: After a frame has been stored, a new frame is dropped (memory and flags unchanged) until the host reads offset 0. The next frame after that read is stored over the old one.
- R5: A control write (cfg_sel 0) with cfg_wdata[0]=1 sets the flush bit, seen on cfg_state[0] for exactly one cycle. The flush abandons any frame in progress and re-arms the buffer. Bytes that follow without a first-byte mark are ignored.
- R6: A soft_rst pulse clears the status flags, abandons any frame in progress and re-arms the buffer without a host read of offset 0.
- R7: While the decode-inhibit bit (control write, cfg_wdata[1]; cfg_state[1]) is 1, a frame whose first byte arrives is dropped completely: no byte is written and no flag is raised. Clearing the bit re-enables reception.
- R8: A frame that had already started when decode-inhibit is set is still stored and completed.
- R9: A frame that ends within DEPTH bytes sets status bit 0 (receive) two clock edges after its last byte is taken.
- R10: A completed frame whose byte at offset 1 (low frame-control byte) has bit 3 set also sets status bit 1 (security).
- R11: A stat_rd pulse places the flags on stat_data after the next edge and clears them in the same edge. A flag event arriving in that same cycle is kept.
- R12: irq is 1 exactly when (receive flag and cfg_state[2]) or (security flag and cfg_state[3]). The enable bits are written with cfg_sel 1: cfg_wdata[0] is the receive enable and cfg_wdata[1] is the security enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| soft_rst | input | 1 | Soft reset pulse: clear flags, re-arm buffer |
| rx_we | input | 1 | Receive byte strobe |
| rx_first | input | 1 | Marks the first byte of a frame |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_data | input | DATA_W | Receive byte |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | ADDR_W | Host read offset |
| host_rd_data | output | DATA_W | Read data, one cycle after the strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: control (flush, inhibit), 1: interrupt enables |
| cfg_wdata | input | 2 | Configuration write data |
| cfg_state | output | 4 | {security enable, receive enable, inhibit, flush} |
| stat_rd | input | 1 | Status read-and-clear strobe |
| stat_data | output | 3 | {overflow, security, receive} captured by stat_rd |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches every cycle for properties that hold at all times. No write may address beyond the storage. Flush must clear itself one cycle after it is set. A frame opening while inhibited or while the buffer is claimed must not write. A status read must leave the flags empty. The receive flag may only rise after a clean completion, and the interrupt may only rise when a flag is held. Whether the right bytes land at the right offsets can only be shown by the bench's scenarios. The same holds for whether a frame started before the inhibit still completes, and for the exact fit and one-past-fit frame sizes. The bench sweeps frame lengths and checks every stored offset against values it computes itself.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_FILL = 2'd1,
      WS_SKIP = 2'd2
   } wr_state_e;

   localparam int ST_RX  = 0;
   localparam int ST_SEC = 1;
   localparam int ST_OVF = 2;
   localparam int ST_W   = 3;

   localparam logic CFG_SEL_CTRL = 1'b0;
   localparam logic CFG_SEL_EN   = 1'b1;
endpackage

// File: rtl/rfb_store.sv
module rfb_store #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 128,
   parameter bit EXTRA_STAGE = 1'b0,
   localparam int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_addr];
   end

   generate
      if (EXTRA_STAGE) begin : g_pipe
         logic [DATA_W-1:0] rd_q2;
         always_ff @(posedge clk) rd_q2 <= rd_q;
         assign rd_data = rd_q2;
      end else begin : g_direct
         assign rd_data = rd_q;
      end
   endgenerate
endmodule

// File: rtl/rfb_wr_ctrl.sv
module rfb_wr_ctrl
   import rfb_pkg::*;
#(
   parameter int DEPTH    = 128,
   localparam int PTR_W   = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             flush,
   input  logic             inhibit,
   input  logic             rx_we,
   input  logic             rx_first,
   input  logic             rx_last,
   input  logic             sec_in,
   input  logic             host_rd_zero,
   output logic             mem_we,
   output logic [PTR_W-1:0] mem_waddr,
   output logic             idle,
   output logic             armed,
   output logic             done,
   output logic             done_ok,
   output logic             done_sec,
   output logic             done_ovf
);
   wr_state_e        state;
   logic [PTR_W-1:0] ptr;
   logic             ovf;
   logic             sec;
   logic             start_ok;
   logic             in_range;
   logic             ovf_now;
   logic             sec_now;

   assign idle     = (state == WS_IDLE);
   assign start_ok = rx_we && rx_first && idle && armed && !inhibit;
   assign in_range = (ptr < PTR_W'(DEPTH));
   assign mem_we   = start_ok || (rx_we && (state == WS_FILL) && in_range);
   assign mem_waddr = start_ok ? '0 : ptr;
   assign ovf_now  = ovf || !in_range;
   assign sec_now  = (ptr == PTR_W'(1)) ? sec_in : sec;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst || flush) begin
         state    <= WS_IDLE;
         ptr      <= '0;
         armed    <= 1'b1;
         ovf      <= 1'b0;
         sec      <= 1'b0;
         done     <= 1'b0;
         done_ok  <= 1'b0;
         done_sec <= 1'b0;
         done_ovf <= 1'b0;
      end else begin
         done <= 1'b0;
         if (host_rd_zero && (state != WS_FILL)) armed <= 1'b1;
         if (rx_we) begin
            unique case (state)
               WS_IDLE: begin
                  if (rx_first) begin
                     if (armed && !inhibit) begin
                        armed <= 1'b0;
                        ptr   <= PTR_W'(1);
                        ovf   <= 1'b0;
                        sec   <= 1'b0;
                        if (rx_last) begin
                           done     <= 1'b1;
                           done_ok  <= 1'b1;
                           done_sec <= 1'b0;
                           done_ovf <= 1'b0;
                        end else begin
                           state <= WS_FILL;
                        end
                     end else if (!rx_last) begin
                        state <= WS_SKIP;
                     end
                  end
               end
               WS_FILL: begin
                  if (in_range) ptr <= ptr + PTR_W'(1);
                  else          ovf <= 1'b1;
                  if (ptr == PTR_W'(1)) sec <= sec_in;
                  if (rx_last) begin
                     state    <= WS_IDLE;
                     done     <= 1'b1;
                     done_ok  <= !ovf_now;
                     done_sec <= !ovf_now && sec_now;
                     done_ovf <= ovf_now;
                  end
               end
               WS_SKIP: begin
                  if (rx_last) state <= WS_IDLE;
               end
               default: state <= WS_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rfb_irq.sv
module rfb_irq
   import rfb_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            done,
   input  logic            done_ok,
   input  logic            done_sec,
   input  logic            done_ovf,
   input  logic            stat_rd,
   output logic [ST_W-1:0] flags,
   output logic [ST_W-1:0] stat_data
);
   logic [ST_W-1:0] evt;
   logic [ST_W-1:0] flags_nxt;

   always_comb begin
      evt          = '0;
      evt[ST_RX]   = done && done_ok;
      evt[ST_SEC]  = done && done_sec;
      evt[ST_OVF]  = done && done_ovf;
      flags_nxt    = (stat_rd ? '0 : flags) | evt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         flags     <= '0;
         stat_data <= '0;
      end else begin
         flags <= flags_nxt;
         if (stat_rd) stat_data <= flags;
      end
   end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
   import rfb_pkg::*;
#(
   parameter int DEPTH          = 128,
   parameter int DATA_W         = 8,
   parameter int SEC_BIT        = 3,
   parameter bit EXTRA_RD_STAGE = 1'b0,
   localparam int ADDR_W        = $clog2(DEPTH),
   localparam int PTR_W         = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rx_we,
   input  logic              rx_first,
   input  logic              rx_last,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              host_rd_en,
   input  logic [ADDR_W-1:0] host_rd_addr,
   output logic [DATA_W-1:0] host_rd_data,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [1:0]        cfg_wdata,
   output logic [3:0]        cfg_state,
   input  logic              stat_rd,
   output logic [ST_W-1:0]   stat_data,
   output logic              irq
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_frame_buf: DEPTH must be a power of two of at least 4");
      end
      if (SEC_BIT >= DATA_W) begin : g_bad_sec
         $error("rx_frame_buf: SEC_BIT must lie inside the data byte");
      end
   endgenerate

   logic             flush_q;
   logic             decinv_q;
   logic             rxie_q;
   logic             secie_q;
   logic             host_rd_zero;
   logic             mem_we;
   logic [PTR_W-1:0] mem_waddr;
   logic             store_we;
   logic             wr_idle;
   logic             wr_armed;
   logic             done;
   logic             done_ok;
   logic             done_sec;
   logic             done_ovf;
   logic [ST_W-1:0]  flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_q  <= 1'b0;
         decinv_q <= 1'b0;
         rxie_q   <= 1'b0;
         secie_q  <= 1'b0;
      end else begin
         if (cfg_we && cfg_sel == CFG_SEL_CTRL) begin
            flush_q  <= cfg_wdata[0];
            decinv_q <= cfg_wdata[1];
         end else begin
            flush_q <= 1'b0;
         end
         if (cfg_we && cfg_sel == CFG_SEL_EN) begin
            rxie_q  <= cfg_wdata[0];
            secie_q <= cfg_wdata[1];
         end
      end
   end

   assign cfg_state    = {secie_q, rxie_q, decinv_q, flush_q};
   assign host_rd_zero = host_rd_en && (host_rd_addr == '0);
   assign store_we     = mem_we && !mem_waddr[ADDR_W];

   rfb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .flush        (flush_q),
      .inhibit      (decinv_q),
      .rx_we        (rx_we),
      .rx_first     (rx_first),
      .rx_last      (rx_last),
      .sec_in       (rx_data[SEC_BIT]),
      .host_rd_zero (host_rd_zero),
      .mem_we       (mem_we),
      .mem_waddr    (mem_waddr),
      .idle         (wr_idle),
      .armed        (wr_armed),
      .done         (done),
      .done_ok      (done_ok),
      .done_sec     (done_sec),
      .done_ovf     (done_ovf)
   );

   rfb_store #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .EXTRA_STAGE (EXTRA_RD_STAGE)
   ) u_store (
      .clk     (clk),
      .wr_en   (store_we),
      .wr_addr (mem_waddr[ADDR_W-1:0]),
      .wr_data (rx_data),
      .rd_en   (host_rd_en),
      .rd_addr (host_rd_addr),
      .rd_data (host_rd_data)
   );

   rfb_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .done      (done),
      .done_ok   (done_ok),
      .done_sec  (done_sec),
      .done_ovf  (done_ovf),
      .stat_rd   (stat_rd),
      .flags     (flags),
      .stat_data (stat_data)
   );

   assign irq = (flags[ST_RX] && rxie_q) || (flags[ST_SEC] && secie_q);
endmodule

// File: rtl/rfb_checker.sv
module rfb_checker #(
   parameter int DEPTH = 128,
   parameter int PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             flush_q,
   input logic             decinv_q,
   input logic             cfg_we,
   input logic             cfg_sel,
   input logic [1:0]       cfg_wdata,
   input logic             rx_we,
   input logic             rx_first,
   input logic             mem_we,
   input logic [PTR_W-1:0] mem_waddr,
   input logic             wr_idle,
   input logic             wr_armed,
   input logic             done,
   input logic             done_ok,
   input logic             stat_rd,
   input logic [2:0]       flags,
   input logic             irq
);
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_waddr < PTR_W'(DEPTH)));

   assert_flush_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !(cfg_we && !cfg_sel && cfg_wdata[0])) |=> !flush_q);

   assert_inhibit_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_we && rx_first && wr_idle && decinv_q) |-> !mem_we);

   assert_claimed_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_we && rx_first && wr_idle && !wr_armed && !soft_rst && !flush_q) |-> !mem_we);

   assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (flags == 3'b000 && wr_armed));

   assert_stat_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done) |=> (flags == 3'b000));

   assert_rx_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(done && done_ok));

   assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags[0] || flags[1]));
endmodule

bind rx_frame_buf rfb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .flush_q   (flush_q),
   .decinv_q  (decinv_q),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .rx_we     (rx_we),
   .rx_first  (rx_first),
   .mem_we    (mem_we),
   .mem_waddr (mem_waddr),
   .wr_idle   (wr_idle),
   .wr_armed  (wr_armed),
   .done      (done),
   .done_ok   (done_ok),
   .stat_rd   (stat_rd),
   .flags     (flags),
   .irq       (irq)
);

// File: tb/rx_frame_buf_tb.sv
`timescale 1ns/1ps
module rx_frame_buf_tb;
   localparam int DEPTH = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       rx_we = 1'b0;
   logic       rx_first = 1'b0;
   logic       rx_last = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       host_rd_en = 1'b0;
   logic [6:0] host_rd_addr = 7'h00;
   logic [7:0] host_rd_data;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [1:0] cfg_wdata = 2'b00;
   logic [3:0] cfg_state;
   logic       stat_rd = 1'b0;
   logic [2:0] stat_data;
   logic       irq;

   int tests = 0;
   int fails = 0;
   logic [7:0] frm [0:255];

   always #2 clk = ~clk;

   rx_frame_buf u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .rx_we(rx_we), .rx_first(rx_first), .rx_last(rx_last), .rx_data(rx_data),
      .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_state(cfg_state),
      .stat_rd(stat_rd), .stat_data(stat_data), .irq(irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int n, input int seed);
      frm[0] = 8'(n - 3);
      for (int i = 1; i < n; i++) frm[i] = 8'((i * 29 + n * 11 + seed * 53) & 255);
   endtask

   function automatic int exp_stat(input int n);
      if (n > DEPTH) return 4;
      return ((n >= 2 && frm[1][3]) ? 2 : 0) + 1;
   endfunction

   task automatic send_range(input int lo, input int hi, input int n);
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         rx_we = 1'b1; rx_data = frm[i];
         rx_first = (i == 0); rx_last = (i == n - 1);
      end
      @(negedge clk);
      rx_we = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
   endtask

   task automatic read_stat(output int v);
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0; v = int'(stat_data);
   endtask

   task automatic host_read(input int a, output int v);
      @(negedge clk); host_rd_en = 1'b1; host_rd_addr = 7'(a);
      @(negedge clk); host_rd_en = 1'b0; v = int'(host_rd_data);
   endtask

   task automatic cfg_write(input logic sel, input logic [1:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // Reads offsets 1..stored-1 then offset 0, which re-arms the buffer.
   task automatic verify(input int n, input string req);
      int v;
      int m;
      m = (n > DEPTH) ? DEPTH : n;
      for (int i = 1; i < m; i++) begin
         host_read(i, v);
         check(req, $sformatf("byte %0d of %0d-byte frame", i, n), v, int'(frm[i]));
      end
      host_read(0, v);
      check(req, $sformatf("length byte of %0d-byte frame", n), v, int'(frm[0]));
   endtask

   task automatic frame_expect(input int n, input int seed, input string req);
      int s;
      fill(n, seed);
      send_range(0, n - 1, n);
      read_stat(s);
      check(req, $sformatf("status after %0d-byte frame", n), s, exp_stat(n));
      verify(n, req);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int s;
      int v;
      logic [7:0] keep1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "irq", int'(irq), 0);
      check("R1", "stat_data", int'(stat_data), 0);
      check("R1", "cfg_state", int'(cfg_state), 0);

      // R2 R9 R10 sweep of small frame sizes
      for (int n = 3; n <= 11; n++) frame_expect(n, n, "R2_R9_R10");
      // R2 exact fit
      frame_expect(DEPTH, 7, "R2");
      // R3 one byte past the storage
      frame_expect(DEPTH + 1, 9, "R3");

      // R4 claimed buffer drops a second frame
      fill(6, 100);
      send_range(0, 5, 6);
      read_stat(s);
      check("R4", "status first frame", s, exp_stat(6));
      keep1 = frm[1];
      fill(7, 101);
      send_range(0, 6, 7);
      read_stat(s);
      check("R4", "status dropped frame", s, 0);
      host_read(1, v);
      check("R4", "old byte 1 kept", v, int'(keep1));
      host_read(0, v);
      check("R4", "old length kept", v, 3);
      frame_expect(7, 101, "R4");

      // R7 inhibit drops a whole frame
      keep1 = frm[1];
      cfg_write(1'b0, 2'b10);
      check("R7", "inhibit bit", int'(cfg_state[1]), 1);
      fill(5, 102);
      send_range(0, 4, 5);
      read_stat(s);
      check("R7", "status inhibited frame", s, 0);
      host_read(1, v);
      check("R7", "byte 1 untouched", v, int'(keep1));
      cfg_write(1'b0, 2'b00);
      frame_expect(5, 102, "R7");

      // R8 inhibit set mid-frame
      fill(9, 103);
      send_range(0, 3, 9);
      cfg_write(1'b0, 2'b10);
      send_range(4, 8, 9);
      read_stat(s);
      check("R8", "status frame started before inhibit", s, exp_stat(9));
      verify(9, "R8");
      cfg_write(1'b0, 2'b00);

      // R5 flush self-clears, abandons frame, re-arms
      fill(8, 104);
      send_range(0, 2, 8);
      cfg_write(1'b0, 2'b01);
      check("R5", "flush bit set", int'(cfg_state[0]), 1);
      @(negedge clk);
      check("R5", "flush bit cleared", int'(cfg_state[0]), 0);
      send_range(3, 7, 8);
      read_stat(s);
      check("R5", "status abandoned frame", s, 0);
      frame_expect(6, 105, "R5");

      // R6 soft reset clears flags and re-arms
      fill(5, 106);
      send_range(0, 4, 5);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      read_stat(s);
      check("R6", "status after soft reset", s, 0);
      frame_expect(7, 107, "R6");

      // R11 flags cleared by the read
      fill(4, 108);
      send_range(0, 3, 4);
      read_stat(s);
      check("R11", "first status read", s, exp_stat(4));
      read_stat(s);
      check("R11", "second status read", s, 0);
      verify(4, "R11");

      // R12 interrupt gating, R10 security flag
      cfg_write(1'b1, 2'b01);
      fill(6, 109); frm[1] = frm[1] & 8'hF7;
      send_range(0, 5, 6);
      @(negedge clk);
      check("R12", "irq with receive enable", int'(irq), 1);
      read_stat(s);
      check("R12", "status plain frame", s, 1);
      check("R12", "irq after status read", int'(irq), 0);
      verify(6, "R12");
      cfg_write(1'b1, 2'b10);
      fill(6, 110); frm[1] = frm[1] & 8'hF7;
      send_range(0, 5, 6);
      @(negedge clk);
      check("R12", "irq security-only enable, plain frame", int'(irq), 0);
      read_stat(s);
      verify(6, "R12");
      fill(6, 111); frm[1] = frm[1] | 8'h08;
      send_range(0, 5, 6);
      @(negedge clk);
      check("R12", "irq security-only enable, secured frame", int'(irq), 1);
      read_stat(s);
      check("R10", "status secured frame", s, 3);
      verify(6, "R10");
      cfg_write(1'b1, 2'b00);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule